// File: doc/BRIEF.md
# Flash plane concurrency and suspend controller

This block is the behavioural control core of a word-addressed flash array that is split into four equal planes. It tracks one embedded program or erase at a time, runs it against a countdown timer, and for every incoming request decides whether it may proceed, must be refused, or is answered with operation status instead of array data. Reads to a plane other than the busy one are served at once. An erase can be put on hold so that reads and programs reach other sectors, and a program can be put on hold so that other words can be read. During an erase hold, a program may run in a different sector; this is the nested program.

The storage is a scaled register file of 64 words of 16 bits. Words 0 to 7 are eight one-word small sectors. The remaining words form 8-word main sectors, and each sector has its own lockout input. Every request gets a response exactly one cycle later. The response carries a code: array data, status, accepted, or refused. Software polls completion by reading the busy plane: bit 7 of the status word is the polling bit and bit 6 is the toggle bit.

FSM states: ST_IDLE (no operation), ST_ERASE (erase running), ST_PROG (program running), ST_ESUSP (erase on hold), ST_PSUSP (program on hold), ST_NPROG (nested program running while an erase is on hold).

The transitions are:
- IDLE to PROG, or IDLE to ERASE, on an accepted request.
- ERASE to IDLE, or PROG to IDLE, when the timer expires.
- ERASE to ESUSP, or PROG to PSUSP, on suspend.
- ESUSP to ERASE, or PSUSP to PROG, on resume.
- ESUSP to NPROG on an accepted program.
- NPROG to ESUSP when the nested program finishes.
- Any state to IDLE on reset.

Top module: `fpc_ctrl`

## Requirements
- R1: Address map. Word address bits [5:4] select plane A to D (0 to 3). Words 0 to 7 are small sectors 0 to 7. Words 8 and up form 8-word main sectors 8 to 14, with sector = 8 + (addr-8)/8. An erase touches exactly its own sector's words.
- R2: After reset every word reads 0xFFFF, busy and susp are 0, and rsp_valid is 0.
- R3: Every request cycle (req_valid=1) produces exactly one response cycle one clock later. The response codes are 0 = array data, 1 = status, 2 = accepted, 3 = refused. Data is 0 for codes 2 and 3.
- R4: An accepted program (op 1) stores old AND new data and keeps busy high for 6 cycles.
- R5: An accepted erase (op 2) sets every word of the addressed sector to 0xFFFF. Busy stays high for 20 cycles for a small sector and 70 cycles for a main sector.
- R6: A program or erase to a sector whose sect_lock bit is 1 is refused and leaves the array unchanged.
- R7: While a program or erase runs and is not on hold, a read (op 0) to another plane returns array data.
- R8: A read of the busy plane returns status. In the status word, bit 7 is the complement of bit 7 of the data being written (0 for an erase). Bit 6 is the toggle bit: it is 0 on the first status read after an operation starts and flips on each status read. All other bits are 0.
- R9: A program or erase request while an operation runs and is not on hold is refused.
- R10: Suspend (op 3) of an erase is accepted. During the hold, a read of the erased sector returns status, and reads of other sectors, the same plane included, return data. Programs to other unlocked sectors are accepted, while a program to the erased sector and any erase are refused.
- R11: Suspend of a program is accepted. During the hold, a read of the programmed word returns status and other words return data. Program and erase are refused.
- R12: Resume (op 4) continues the held operation from its remaining count, so total busy cycles equal the nominal duration. Resume or suspend with nothing to act on is refused and has no effect.
- R13: The nested program completes and returns to the erase hold. Suspend and resume during the nested program are refused.
- R14: Asserting rst_n low mid-operation aborts the operation, clears any hold, and returns to idle with the array at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 suspend, 4 resume |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Program data |
| sect_lock | input | 15 | Per-sector write lockout, bit n for sector n |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Response kind (see R3) |
| rsp_data | output | 16 | Array word or status word |
| busy | output | 1 | An embedded operation is counting |
| susp | output | 1 | An erase or program is on hold |

## Verification
Each response is registered, so it appears in the cycle after the request cycle. The scoreboard pushes the expected item when it drives a request and pops it on the next falling edge that shows rsp_valid. Busy rises in the cycle after an accepted program or erase, so the bench counts busy cycles at falling edges and compares the total with 6, 20, 70 or 76 cycles after busy falls. Array contents are compared only once busy has fallen, and reset effects are sampled on the falling edge after rst_n drops.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int DATA_W      = 16;
    localparam int PLANES      = 4;
    localparam int PLANE_LG    = 4;
    localparam int SMALL_LG    = 0;
    localparam int MAIN_LG     = 3;
    localparam int NUM_SMALL   = 8;
    localparam int ADDR_W      = PLANE_LG + $clog2(PLANES);
    localparam int WORDS       = 1 << ADDR_W;
    localparam int SMALL_SPAN  = NUM_SMALL << SMALL_LG;
    localparam int NUM_MAIN    = (WORDS - SMALL_SPAN) >> MAIN_LG;
    localparam int NUM_SECT    = NUM_SMALL + NUM_MAIN;
    localparam int SECT_W      = $clog2(NUM_SECT);
    localparam int PLANE_W     = $clog2(PLANES);
    localparam int T_PROG      = 6;
    localparam int T_ERS_SMALL = 20;
    localparam int T_ERS_MAIN  = 70;
    localparam int CNT_W       = $clog2(T_ERS_MAIN + 1);
    localparam int STAT_POLL   = 7;
    localparam int STAT_TOG    = 6;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [SECT_W-1:0]  sect_t;
    typedef logic [PLANE_W-1:0] plane_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_PROG    = 3'd1,
        OP_ERASE   = 3'd2,
        OP_SUSPEND = 3'd3,
        OP_RESUME  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        RSP_DATA   = 2'd0,
        RSP_STATUS = 2'd1,
        RSP_ACK    = 2'd2,
        RSP_REJ    = 2'd3
    } rsp_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ERASE, ST_PROG, ST_ESUSP, ST_PSUSP, ST_NPROG
    } state_e;

    function automatic sect_t sect_of(addr_t a);
        if (int'(a) < SMALL_SPAN)
            return sect_t'(int'(a) >> SMALL_LG);
        return sect_t'(NUM_SMALL + ((int'(a) - SMALL_SPAN) >> MAIN_LG));
    endfunction
endpackage

// File: rtl/fpc_decode.sv
module fpc_decode
    import fpc_pkg::*;
(
    input  addr_t  addr,
    output sect_t  sect,
    output plane_t plane
);
    assign sect  = sect_of(addr);
    assign plane = addr[ADDR_W-1:PLANE_LG];
endmodule

// File: rtl/fpc_timer.sv
module fpc_timer
    import fpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  cnt_t load_val,
    input  logic run,
    output cnt_t cnt,
    output logic expire
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = run && !load && (cnt == cnt_t'(1));
endmodule

// File: rtl/fpc_array.sv
module fpc_array
    import fpc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t rd_addr,
    output word_t rd_data,
    input  logic  pg_en,
    input  addr_t pg_addr,
    input  word_t pg_data,
    input  logic  er_en,
    input  sect_t er_sect
);
    word_t mem [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        localparam sect_t WSECT = sect_of(addr_t'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '1;
            else if (er_en && er_sect == WSECT)
                mem[i] <= '1;
            else if (pg_en && pg_addr == addr_t'(i))
                mem[i] <= mem[i] & pg_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
    import fpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [NUM_SECT-1:0] sect_lock,
    output logic                rsp_valid,
    output logic [1:0]          rsp_code,
    output logic [DATA_W-1:0]   rsp_data,
    output logic                busy,
    output logic                susp
);
    state_e state, state_nx;
    op_e    op;
    logic   rd_req, pg_req, er_req, sp_req, rs_req;
    sect_t  q_sect, p_sect;
    plane_t q_plane, p_plane, n_plane;
    addr_t  p_addr, n_addr, pg_addr;
    word_t  p_data, n_data, pg_data, rd_data, status;
    logic   locked, run, expire, ld, acc, susp_ok, res_ok;
    logic   pg_en, er_en, blocked, tgt, tog;
    cnt_t   cnt, ld_val, saved;
    rsp_e   rsp_code_q;

    assign op     = op_e'(req_op);
    assign rd_req = req_valid && op == OP_READ;
    assign pg_req = req_valid && op == OP_PROG;
    assign er_req = req_valid && op == OP_ERASE;
    assign sp_req = req_valid && op == OP_SUSPEND;
    assign rs_req = req_valid && op == OP_RESUME;
    assign locked = sect_lock[q_sect];
    assign run    = state inside {ST_ERASE, ST_PROG, ST_NPROG};
    assign busy   = run;
    assign susp   = state inside {ST_ESUSP, ST_PSUSP, ST_NPROG};
    assign rsp_code = rsp_code_q;

    fpc_decode u_dec (.addr(req_addr), .sect(q_sect), .plane(q_plane));

    fpc_timer u_tmr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
        .run(run), .cnt(cnt), .expire(expire)
    );

    fpc_array u_arr (
        .clk(clk), .rst_n(rst_n), .rd_addr(req_addr), .rd_data(rd_data),
        .pg_en(pg_en), .pg_addr(pg_addr), .pg_data(pg_data),
        .er_en(er_en), .er_sect(p_sect)
    );

    // next state, timer control and array strobes
    always_comb begin
        state_nx = state;
        acc      = 1'b0;
        susp_ok  = 1'b0;
        res_ok   = 1'b0;
        ld       = 1'b0;
        ld_val   = '0;
        pg_en    = 1'b0;
        er_en    = 1'b0;
        pg_addr  = p_addr;
        pg_data  = p_data;
        unique case (state)
            ST_IDLE: begin
                if (pg_req && !locked) begin
                    state_nx = ST_PROG;
                    acc = 1'b1; ld = 1'b1; ld_val = cnt_t'(T_PROG);
                end else if (er_req && !locked) begin
                    state_nx = ST_ERASE;
                    acc = 1'b1; ld = 1'b1;
                    ld_val = (q_sect < sect_t'(NUM_SMALL)) ? cnt_t'(T_ERS_SMALL)
                                                          : cnt_t'(T_ERS_MAIN);
                end
            end
            ST_ERASE: begin
                if (expire) begin
                    er_en = 1'b1; state_nx = ST_IDLE;
                end else if (sp_req) begin
                    susp_ok = 1'b1; state_nx = ST_ESUSP;
                end
            end
            ST_PROG: begin
                if (expire) begin
                    pg_en = 1'b1; state_nx = ST_IDLE;
                end else if (sp_req) begin
                    susp_ok = 1'b1; state_nx = ST_PSUSP;
                end
            end
            ST_ESUSP: begin
                if (rs_req) begin
                    res_ok = 1'b1; ld = 1'b1; ld_val = saved; state_nx = ST_ERASE;
                end else if (pg_req && !locked && q_sect != p_sect) begin
                    acc = 1'b1; ld = 1'b1; ld_val = cnt_t'(T_PROG); state_nx = ST_NPROG;
                end
            end
            ST_PSUSP: begin
                if (rs_req) begin
                    res_ok = 1'b1; ld = 1'b1; ld_val = saved; state_nx = ST_PROG;
                end
            end
            ST_NPROG: begin
                if (expire) begin
                    pg_en = 1'b1; pg_addr = n_addr; pg_data = n_data;
                    state_nx = ST_ESUSP;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // read gating and status word
    always_comb begin
        unique case (state)
            ST_ERASE, ST_PROG: blocked = (q_plane == p_plane);
            ST_ESUSP:          blocked = (q_sect == p_sect);
            ST_PSUSP:          blocked = (req_addr == p_addr);
            ST_NPROG:          blocked = (q_sect == p_sect) || (q_plane == n_plane);
            default:           blocked = 1'b0;
        endcase
        if (state == ST_NPROG && q_sect != p_sect)
            tgt = n_data[STAT_POLL];
        else if (state inside {ST_ERASE, ST_ESUSP, ST_NPROG})
            tgt = 1'b1;
        else
            tgt = p_data[STAT_POLL];
        status = '0;
        status[STAT_POLL] = ~tgt;
        status[STAT_TOG]  = tog;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_addr <= '0; p_data <= '0; p_sect <= '0; p_plane <= '0;
            n_addr <= '0; n_data <= '0; n_plane <= '0; saved <= '0;
        end else begin
            if (acc && state == ST_ESUSP) begin
                n_addr <= req_addr; n_data <= req_wdata; n_plane <= q_plane;
            end else if (acc) begin
                p_addr <= req_addr; p_data <= req_wdata;
                p_sect <= q_sect;   p_plane <= q_plane;
            end
            if (susp_ok)
                saved <= cnt - 1'b1;
        end
    end

    // responses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_code_q <= RSP_DATA;
            rsp_data   <= '0;
            tog        <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            rsp_data   <= '0;
            rsp_code_q <= RSP_REJ;
            if (req_valid) begin
                unique case (op)
                    OP_READ: begin
                        if (blocked) begin
                            rsp_code_q <= RSP_STATUS;
                            rsp_data   <= status;
                            tog        <= ~tog;
                        end else begin
                            rsp_code_q <= RSP_DATA;
                            rsp_data   <= rd_data;
                        end
                    end
                    OP_PROG, OP_ERASE: rsp_code_q <= acc ? RSP_ACK : RSP_REJ;
                    OP_SUSPEND:        rsp_code_q <= susp_ok ? RSP_ACK : RSP_REJ;
                    OP_RESUME:         rsp_code_q <= res_ok ? RSP_ACK : RSP_REJ;
                    default:           rsp_code_q <= RSP_REJ;
                endcase
            end
            if (acc)
                tog <= 1'b0;
        end
    end

    // R3: one response per request, one cycle later
    a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R6: locked sector refuses program and erase
    a_r6_locked_rej: assert property (@(posedge clk) disable iff (!rst_n)
        ((pg_req || er_req) && locked) |=> rsp_code_q == RSP_REJ);
    // R7: other-plane read during a running operation returns data
    a_r7_other_plane: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state inside {ST_ERASE, ST_PROG} && q_plane != p_plane)
        |=> rsp_code_q == RSP_DATA);
    // R9: no second operation while one runs
    a_r9_busy_rej: assert property (@(posedge clk) disable iff (!rst_n)
        ((pg_req || er_req) && state inside {ST_ERASE, ST_PROG, ST_PSUSP, ST_NPROG})
        |=> rsp_code_q == RSP_REJ);
    // R12: stray resume is refused and changes nothing
    a_r12_stray_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_req && !(state inside {ST_ESUSP, ST_PSUSP}) && !expire)
        |=> (rsp_code_q == RSP_REJ) && (state == $past(state)));
    // R12: a counting operation never sits at zero
    a_r12_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt != '0);
    // R13: nested program returns to the erase hold
    a_r13_nest_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NPROG && expire) |=> state == ST_ESUSP);
endmodule

// File: tb/tb_fpc_ctrl.sv
module tb_fpc_ctrl;
    import fpc_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                req_valid = 1'b0;
    logic [2:0]          req_op = '0;
    logic [ADDR_W-1:0]   req_addr = '0;
    logic [DATA_W-1:0]   req_wdata = '0;
    logic [NUM_SECT-1:0] sect_lock = '0;
    logic                rsp_valid, busy, susp;
    logic [1:0]          rsp_code;
    logic [DATA_W-1:0]   rsp_data;

    fpc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .sect_lock(sect_lock),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data(rsp_data),
        .busy(busy), .susp(susp)
    );

    typedef struct {
        logic [1:0]  code;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_checks = 0;
    int          n_fail   = 0;
    int          bcount   = 0;
    bit          done     = 1'b0;
    logic [15:0] model [WORDS];

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] stw(bit b7, bit t);
        return {8'h00, b7, t, 6'h00};
    endfunction

    // driver: one request cycle, expected item queued
    task automatic issue(op_e op, int addr, logic [15:0] wd,
                         logic [1:0] code, logic [15:0] ed, string tag);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = addr_t'(addr);
        req_wdata = wd;
        sb.push_back('{code, ed, tag});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        issue(OP_READ, a, 16'h0, RSP_DATA, model[a], tag);
    endtask

    task automatic rd_st(int a, bit b7, bit t, string tag);
        issue(OP_READ, a, 16'h0, RSP_STATUS, stw(b7, t), tag);
    endtask

    task automatic prog_ok(int a, logic [15:0] d, string tag);
        issue(OP_PROG, a, d, RSP_ACK, 16'h0, tag);
        model[a] = model[a] & d;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare responses with the queue
    always @(negedge clk) begin
        if (busy) bcount++;
        if (rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_code == e.code, e.tag, "rsp_code", int'(rsp_code), int'(e.code));
                check(rsp_data == e.data, e.tag, "rsp_data", int'(rsp_data), int'(e.data));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        sect_lock = '0;
        sect_lock[10] = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R2 reset state
        check(busy == 1'b0, "R2", "busy after reset", busy, 0);
        check(susp == 1'b0, "R2", "susp after reset", susp, 0);
        check(rsp_valid == 1'b0, "R2", "rsp_valid after reset", rsp_valid, 0);
        rd(5, "R2");
        rd(63, "R2");

        // R4 program AND, duration
        bcount = 0;
        prog_ok(20, 16'h12F4, "R4");
        check(busy == 1'b1, "R4", "busy during program", busy, 1);
        wait_idle();
        check(bcount == T_PROG, "R4", "program busy cycles", bcount, T_PROG);
        rd(20, "R4");
        prog_ok(20, 16'hFF0F, "R4");
        wait_idle();
        rd(20, "R4");

        // R8 status, R7 other plane, R9 refusal
        prog_ok(20, 16'h3300, "R8");
        rd_st(22, 1'b1, 1'b0, "R8");
        rd_st(22, 1'b1, 1'b1, "R8");
        rd(40, "R7");
        issue(OP_PROG, 18, 16'h0, RSP_REJ, 16'h0, "R9");
        issue(OP_ERASE, 18, 16'h0, RSP_REJ, 16'h0, "R9");
        wait_idle();
        rd(20, "R4");
        rd(18, "R9");

        // R6 locked sector 10 (words 24..31)
        issue(OP_PROG, 24, 16'h0, RSP_REJ, 16'h0, "R6");
        issue(OP_ERASE, 26, 16'h0, RSP_REJ, 16'h0, "R6");
        check(busy == 1'b0, "R6", "busy after locked request", busy, 0);
        rd(24, "R6");

        // R5 small sector erase, R1 map
        prog_ok(3, 16'h0000, "R5");
        wait_idle();
        prog_ok(4, 16'h0000, "R1");
        wait_idle();
        bcount = 0;
        issue(OP_ERASE, 3, 16'h0, RSP_ACK, 16'h0, "R5");
        model[3] = 16'hFFFF;
        rd_st(15, 1'b0, 1'b0, "R1");
        rd(16, "R1");
        rd_st(2, 1'b0, 1'b1, "R8");
        wait_idle();
        check(bcount == T_ERS_SMALL, "R5", "small erase cycles", bcount, T_ERS_SMALL);
        rd(3, "R5");
        rd(4, "R1");

        // R5 main sector erase (sector 13, words 48..55)
        prog_ok(50, 16'h0000, "R5");
        wait_idle();
        prog_ok(56, 16'h0000, "R1");
        wait_idle();
        bcount = 0;
        issue(OP_ERASE, 50, 16'h0, RSP_ACK, 16'h0, "R5");
        for (int i = 48; i < 56; i++) model[i] = 16'hFFFF;
        rd_st(60, 1'b0, 1'b0, "R8");
        rd_st(60, 1'b0, 1'b1, "R8");
        wait_idle();
        check(bcount == T_ERS_MAIN, "R5", "main erase cycles", bcount, T_ERS_MAIN);
        rd(50, "R5");
        rd(55, "R1");
        rd(56, "R1");

        // R10 erase hold, R13 nested program, R12 resume
        prog_ok(33, 16'h00FF, "R10");
        wait_idle();
        bcount = 0;
        issue(OP_ERASE, 32, 16'h0, RSP_ACK, 16'h0, "R10");
        idle(9);
        issue(OP_SUSPEND, 0, 16'h0, RSP_ACK, 16'h0, "R10");
        check(susp == 1'b1, "R10", "susp during erase hold", susp, 1);
        check(busy == 1'b0, "R10", "busy during erase hold", busy, 0);
        rd_st(33, 1'b0, 1'b0, "R10");
        rd(40, "R10");
        issue(OP_PROG, 34, 16'h0, RSP_REJ, 16'h0, "R10");
        issue(OP_ERASE, 60, 16'h0, RSP_REJ, 16'h0, "R10");
        prog_ok(41, 16'h5555, "R13");
        rd_st(42, 1'b1, 1'b0, "R13");
        issue(OP_SUSPEND, 0, 16'h0, RSP_REJ, 16'h0, "R13");
        issue(OP_RESUME, 0, 16'h0, RSP_REJ, 16'h0, "R13");
        wait_idle();
        check(susp == 1'b1, "R13", "still on hold after nested", susp, 1);
        rd(41, "R13");
        rd_st(33, 1'b0, 1'b1, "R13");
        issue(OP_RESUME, 0, 16'h0, RSP_ACK, 16'h0, "R12");
        for (int i = 32; i < 40; i++) model[i] = 16'hFFFF;
        wait_idle();
        check(bcount == T_ERS_MAIN + T_PROG, "R12", "erase+nested busy cycles",
              bcount, T_ERS_MAIN + T_PROG);
        check(susp == 1'b0, "R12", "hold cleared", susp, 0);
        rd(33, "R12");
        rd(41, "R13");

        // R11 program hold
        bcount = 0;
        prog_ok(45, 16'h0F0F, "R11");
        issue(OP_SUSPEND, 0, 16'h0, RSP_ACK, 16'h0, "R11");
        rd_st(45, 1'b1, 1'b0, "R11");
        rd(46, "R11");
        issue(OP_PROG, 47, 16'h0, RSP_REJ, 16'h0, "R11");
        issue(OP_ERASE, 0, 16'h0, RSP_REJ, 16'h0, "R11");
        issue(OP_RESUME, 0, 16'h0, RSP_ACK, 16'h0, "R12");
        wait_idle();
        check(bcount == T_PROG, "R12", "program with hold busy cycles", bcount, T_PROG);
        rd(45, "R11");
        rd(47, "R11");

        // R12 stray resume and suspend
        issue(OP_RESUME, 0, 16'h0, RSP_REJ, 16'h0, "R12");
        issue(OP_SUSPEND, 0, 16'h0, RSP_REJ, 16'h0, "R12");
        check(busy == 1'b0, "R12", "busy after stray commands", busy, 0);
        check(susp == 1'b0, "R12", "susp after stray commands", susp, 0);
        rd(45, "R12");

        // R14 reset aborts
        prog_ok(1, 16'h0000, "R14");
        idle(2);
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
        idle(1);
        check(busy == 1'b0, "R14", "busy in reset", busy, 0);
        check(susp == 1'b0, "R14", "susp in reset", susp, 0);
        rst_n = 1'b1;
        idle(1);
        rd(1, "R14");
        rd(20, "R14");
        issue(OP_RESUME, 0, 16'h0, RSP_REJ, 16'h0, "R14");
        idle(3);
        check(sb.size() == 0, "R3", "responses outstanding", sb.size(), 0);
        finish_run();
    end
endmodule